// File: doc/BRIEF.md
# SPI Event Interrupt and Soft-Reset Unit

This unit sits next to an SPI core and turns that core's single-cycle event strobes into one interrupt request. Each of seven event lines is edge-detected and latched into a sticky status register. A per-event enable register and one global enable bit decide whether latched events reach the interrupt pin. Software acknowledges events by writing ones back to the status register. Bits written as zero stay as they are.

The same register port also offers a soft-reset register. A write of one exact key value starts a reset pulse of fixed length towards the SPI core. The same write returns the status, enable and global enable registers to zero. Any other value written to that offset is discarded.

The register port is a plain single-cycle write strobe with a combinational read path. Reads at offsets without a register return zero.

Top module: `spi_irq_unit`

## Requirements
- R1: After the synchronous reset, `irq_o` and `core_rst_o` are low and the registers at offsets 0x1C, 0x20 and 0x28 read 0.
- R2: A rising edge on `evt_i[i]` sets status bit i (offset 0x20), which reads 1 from the following cycle on. The bit positions are: 0 mode error, 1 selected as slave while idle, 2 TX FIFO drained, 3 TX underflow, 4 RX FIFO filled, 5 RX overflow, 6 TX FIFO half drained. An event line held high does not set the bit again after it has been cleared.
- R3: Writing to offset 0x20 clears every status bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R4: When a new rising edge of an event and a clearing write to the same status bit fall in the same cycle, the bit stays set.
- R5: The enable register at offset 0x28 stores write-data bits 6:0 and reads them back. Bits 31:7 always read 0.
- R6: `irq_o` is high exactly when bit 31 of the global register at offset 0x1C is 1 and status AND enable is nonzero. While bit 31 is 0, status bits still latch. Offset 0x1C reads back bit 31 only.
- R7: Writing 0x0000000A to offset 0x40 drives `core_rst_o` high for exactly PULSE_CYCLES (default 4) cycles, starting in the cycle after the write.
- R8: A write to offset 0x40 with any other value leaves `core_rst_o` low and changes no register.
- R9: The key write of R7 clears the status, enable and global enable registers, so `irq_o` is low in the cycle after it.
- R10: Reads at offset 0x40 and at any offset other than 0x1C, 0x20 and 0x28 return 0. Writes to offsets without a register change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 7 | Event strobes from the SPI core |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Active-high interrupt request |
| core_rst_o | output | 1 | Reset pulse to the SPI core |

## Verification
Events are pulsed one line at a time so that a wrong bit position shows up as a wrong status value. A held-high event line separates true edge detection from level sensing. A clear and a new edge on the same bit are placed in one cycle, and a second bit is cleared in that same write, which shows both the set-wins rule and that the clear itself took effect. The interrupt pin is stepped through the global enable, a mismatched enable mask and acknowledgement, so each gating term is seen to matter on its own. Near-miss keys, including the key with a high bit set, are written to the reset offset. These are set against the exact key, whose pulse is measured cycle by cycle.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int NUM_EVT = 7;
    localparam int GLB_BIT = 31;

    localparam logic [ADDR_W-1:0] OFF_GLB = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_STS = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_ENA = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_RST = 8'h40;

    localparam logic [DATA_W-1:0] RST_KEY = 32'h0000_000A;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GLB,
        SEL_STS,
        SEL_ENA,
        SEL_RST
    } reg_sel_e;

    typedef struct packed {
        logic glb;
        logic sts;
        logic ena;
        logic rst;
    } wr_strobe_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_GLB: s = SEL_GLB;
            OFF_STS: s = SEL_STS;
            OFF_ENA: s = SEL_ENA;
            OFF_RST: s = SEL_RST;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import spi_irq_pkg::*;
(
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [NUM_EVT-1:0] sts_i,
    input  logic [NUM_EVT-1:0] ena_i,
    input  logic               glb_i,
    output wr_strobe_t         strobe_o,
    output logic [DATA_W-1:0]  rdata_o
);

    reg_sel_e sel;

    always_comb begin
        sel = decode_offset(reg_addr);

        strobe_o     = '0;
        strobe_o.glb = reg_wr && (sel == SEL_GLB);
        strobe_o.sts = reg_wr && (sel == SEL_STS);
        strobe_o.ena = reg_wr && (sel == SEL_ENA);
        strobe_o.rst = reg_wr && (sel == SEL_RST);

        rdata_o = '0;
        case (sel)
            SEL_GLB: rdata_o[GLB_BIT] = glb_i;
            SEL_STS: rdata_o[NUM_EVT-1:0] = sts_i;
            SEL_ENA: rdata_o[NUM_EVT-1:0] = ena_i;
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] clr_mask_i,
    input  logic         soft_clr_i,
    output logic [N-1:0] sts_o
);

    logic [N-1:0] evt_q;
    logic [N-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= evt_i;
    end

    assign rise = evt_i & ~evt_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                sts_o[i] <= 1'b0;
            else if (soft_clr_i)    sts_o[i] <= 1'b0;
            else if (rise[i])       sts_o[i] <= 1'b1;
            else if (clr_mask_i[i]) sts_o[i] <= 1'b0;
        end
    end

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        ((rise != '0) && !soft_clr_i) |=> ((sts_o & $past(rise)) == $past(rise))); // R2

    AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        ((~sts_o & $past(sts_o)) != '0) |-> ($past(clr_mask_i) != '0 || $past(soft_clr_i))); // R3

endmodule

// File: rtl/irq_soft_reset.sv
module irq_soft_reset
    import spi_irq_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_rst_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              key_hit_o,
    output logic              core_rst_o
);

    localparam int CW = $clog2(PULSE_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    assign key_hit_o = wr_rst_i && (wdata_i == RST_KEY);

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (key_hit_o)     cnt_q <= CW'(PULSE_CYCLES);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign core_rst_o = (cnt_q != '0);

    AST_PULSE_ONLY_ON_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst_o) |-> $past(key_hit_o)); // R8

    AST_KEY_STARTS_PULSE: assert property (@(posedge clk) disable iff (rst)
        key_hit_o |=> core_rst_o); // R7

endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_o,
    output logic               core_rst_o
);

    wr_strobe_t         strobe;
    logic [NUM_EVT-1:0] sts;
    logic [NUM_EVT-1:0] ena_q;
    logic               glb_q;
    logic [NUM_EVT-1:0] clr_mask;
    logic               soft_clr;

    irq_reg_decode u_decode (
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .sts_i    (sts),
        .ena_i    (ena_q),
        .glb_i    (glb_q),
        .strobe_o (strobe),
        .rdata_o  (reg_rdata)
    );

    assign clr_mask = strobe.sts ? reg_wdata[NUM_EVT-1:0] : '0;

    irq_status_latch #(.N(NUM_EVT)) u_status (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt_i),
        .clr_mask_i (clr_mask),
        .soft_clr_i (soft_clr),
        .sts_o      (sts)
    );

    irq_soft_reset #(.PULSE_CYCLES(PULSE_CYCLES)) u_softrst (
        .clk        (clk),
        .rst        (rst),
        .wr_rst_i   (strobe.rst),
        .wdata_i    (reg_wdata),
        .key_hit_o  (soft_clr),
        .core_rst_o (core_rst_o)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            ena_q <= '0;
            glb_q <= 1'b0;
        end else begin
            if (strobe.ena) ena_q <= reg_wdata[NUM_EVT-1:0];
            if (strobe.glb) glb_q <= reg_wdata[GLB_BIT];
        end
    end

    assign irq_o = glb_q && ((sts & ena_q) != '0);

    AST_IRQ_QUIET_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
        $past(soft_clr) |-> !irq_o); // R9

    AST_ENA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(strobe.ena) && !$past(soft_clr)) |-> $stable(ena_q)); // R10

    AST_GLB_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(strobe.glb) && !$past(soft_clr)) |-> $stable(glb_q)); // R8

endmodule

// File: tb/tb_spi_irq_unit.sv
module tb_spi_irq_unit;
    import spi_irq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NUM_EVT-1:0] evt = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq;
    logic              core_rst;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    spi_irq_unit #(.PULSE_CYCLES(4)) dut (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .reg_addr   (addr),
        .reg_wr     (wr),
        .reg_wdata  (wdata),
        .reg_rdata  (rdata),
        .irq_o      (irq),
        .core_rst_o (core_rst)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
        #1;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic pulse_evt(input logic [6:0] m);
        @(negedge clk);
        evt = m;
        @(negedge clk);
        evt = '0;
        #1;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 irq", irq, 0);
        chk("R1 core_rst", core_rst, 0);
        rd_chk("R1 glb", OFF_GLB, 0);
        rd_chk("R1 sts", OFF_STS, 0);
        rd_chk("R1 ena", OFF_ENA, 0);
    endtask

    task automatic t_event_map;
        logic [31:0] acc = 0;
        for (int i = 0; i < 7; i++) begin
            pulse_evt(7'(1 << i));
            acc = acc | (32'd1 << i);
            rd_chk("R2 per-bit latch", OFF_STS, acc);
        end
        chk("R6 irq low with enables off", irq, 0);
        wr_reg(OFF_STS, 32'h0000_0005);
        rd_chk("R3 partial clear", OFF_STS, 32'h7A);
        wr_reg(OFF_STS, 32'hFFFF_FFFF);
        rd_chk("R3 full clear", OFF_STS, 0);
    endtask

    task automatic t_level_hold;
        @(negedge clk);
        evt = 7'h04;
        @(negedge clk);
        #1;
        rd_chk("R2 held line sets", OFF_STS, 32'h04);
        wr_reg(OFF_STS, 32'h04);
        repeat (3) @(negedge clk);
        #1;
        rd_chk("R2 held line no reset", OFF_STS, 0);
        evt = '0;
        @(negedge clk);
        #1;
        rd_chk("R2 falling no set", OFF_STS, 0);
    endtask

    task automatic t_set_wins;
        pulse_evt(7'h09);
        rd_chk("R4 setup", OFF_STS, 32'h09);
        @(negedge clk);
        evt = 7'h08; addr = OFF_STS; wdata = 32'h09; wr = 1'b1;
        @(negedge clk);
        evt = '0; wr = 1'b0; wdata = '0;
        #1;
        rd_chk("R4 set beats clear", OFF_STS, 32'h08);
        wr_reg(OFF_STS, 32'h7F);
        rd_chk("R3 cleanup", OFF_STS, 0);
    endtask

    task automatic t_enable_rb;
        wr_reg(OFF_ENA, 32'hFFFF_FFFF);
        rd_chk("R5 upper bits zero", OFF_ENA, 32'h7F);
        wr_reg(OFF_ENA, 32'h0000_0012);
        rd_chk("R5 readback", OFF_ENA, 32'h12);
    endtask

    task automatic t_irq_gate;
        wr_reg(OFF_ENA, 32'h04);
        pulse_evt(7'h04);
        rd_chk("R6 latches while global off", OFF_STS, 32'h04);
        chk("R6 irq low global off", irq, 0);
        wr_reg(OFF_GLB, 32'h8000_0000);
        chk("R6 irq high", irq, 1);
        rd_chk("R6 glb readback", OFF_GLB, 32'h8000_0000);
        wr_reg(OFF_GLB, 32'h7FFF_FFFF);
        chk("R6 bit31 only", irq, 0);
        rd_chk("R6 glb readback low", OFF_GLB, 0);
        wr_reg(OFF_GLB, 32'h8000_0000);
        wr_reg(OFF_ENA, 32'h01);
        chk("R6 enable mismatch", irq, 0);
        wr_reg(OFF_ENA, 32'h04);
        chk("R6 enable match", irq, 1);
        wr_reg(OFF_STS, 32'h04);
        chk("R6 ack drops irq", irq, 0);
    endtask

    task automatic t_bad_key;
        wr_reg(OFF_ENA, 32'h7F);
        pulse_evt(7'h21);
        chk("R6 irq before bad keys", irq, 1);
        wr_reg(OFF_RST, 32'h0000_000B);
        chk("R8 key 0B", core_rst, 0);
        wr_reg(OFF_RST, 32'h8000_000A);
        chk("R8 key high bit", core_rst, 0);
        wr_reg(OFF_RST, 32'h0000_0000);
        chk("R8 key zero", core_rst, 0);
        @(negedge clk);
        #1;
        chk("R8 still no pulse", core_rst, 0);
        rd_chk("R8 ena kept", OFF_ENA, 32'h7F);
        rd_chk("R8 sts kept", OFF_STS, 32'h21);
        rd_chk("R8 glb kept", OFF_GLB, 32'h8000_0000);
        chk("R8 irq kept", irq, 1);
    endtask

    task automatic t_key;
        wr_reg(OFF_RST, RST_KEY);
        rd_chk("R9 sts cleared", OFF_STS, 0);
        rd_chk("R9 ena cleared", OFF_ENA, 0);
        rd_chk("R9 glb cleared", OFF_GLB, 0);
        chk("R9 irq low", irq, 0);
        for (int k = 0; k < 4; k++) begin
            chk("R7 pulse high", core_rst, 1);
            @(negedge clk);
            #1;
        end
        chk("R7 pulse ends", core_rst, 0);
    endtask

    task automatic t_unmapped;
        wr_reg(OFF_ENA, 32'h55);
        pulse_evt(7'h02);
        wr_reg(8'h24, 32'hFFFF_FFFF);
        wr_reg(8'h2C, 32'hFFFF_FFFF);
        wr_reg(8'h00, 32'hFFFF_FFFF);
        wr_reg(8'h1D, 32'hFFFF_FFFF);
        rd_chk("R10 read 24", 8'h24, 0);
        rd_chk("R10 read 2C", 8'h2C, 0);
        rd_chk("R10 read 1D", 8'h1D, 0);
        rd_chk("R10 read 40", OFF_RST, 0);
        rd_chk("R10 ena untouched", OFF_ENA, 32'h55);
        rd_chk("R10 sts untouched", OFF_STS, 32'h02);
        rd_chk("R10 glb untouched", OFF_GLB, 0);
        chk("R10 no pulse", core_rst, 0);
    endtask

    initial begin
        t_reset();
        t_event_map();
        t_level_hold();
        t_set_wins();
        t_enable_rb();
        t_irq_gate();
        t_bad_key();
        t_key();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R1 actual running expected done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule